// File: doc/BRIEF.md
# 24-Hour Clock with Hourly Chime

This block keeps time of day as six BCD digits (hours 00 to 23, minutes and seconds 00 to 59). Everything runs on one system clock. A free-running binary divider supplies single-cycle strobes for four jobs: the one-second tick, the key debounce sample, the key scan and an audio tone. No derived clocks are used.

Three active-low push buttons set the time. One advances the minutes, one advances the hours and one holds the seconds at zero. Each button is synchronised and debounced. The scan stage then takes the pressed buttons in a fixed priority and turns each new press into exactly one advance.

A speaker output beeps the tone on four alternate seconds near the end of each hour. A test input can override the speaker with a signal of the user's choosing.

Top module: `clock24_chime`

## Requirements
- R1: The seconds digits count 00 to 59 in BCD, one step per tick. The tick after 59 returns them to 00 and advances the minutes by one.
- R2: The minutes digits count 00 to 59 in BCD. A seconds carry that finds the minutes at 59 returns them to 00 and advances the hours by one.
- R3: The hours digits count 00 to 23 in BCD. An advance at 23 returns them to 00.
- R4: The divider counts every clock and is TICK_BIT+1 bits wide. The seconds tick, the scan strobe and the debounce strobe fire once every 2^(TICK_BIT+1), 2^(SCAN_BIT+1) and 2^(DEB_BIT+1) cycles respectively. The tone is divider bit TONE_BIT. The first tick after reset comes on the 2^(TICK_BIT+1)-th clock edge.
- R5: A key counts as pressed only after its synchronised level has read low on two consecutive debounce samples. A low pulse shorter than one debounce period has no effect. A high sample releases the key at once.
- R6: At each scan strobe the pressed keys are ranked minute-set, then hour-set, then seconds-clear, and only the highest is selected. A press advances its field once, however long it is held. With minute-set and hour-set held together, only the minutes advance. With hour-set and seconds-clear held together, the hours advance and the seconds keep counting.
- R7: While seconds-clear is selected, both seconds digits read 00 and no seconds carry is produced.
- R8: A manual minute advance at 59 returns the minutes to 00 and leaves the hours unchanged.
- R9: A manual hour advance steps 23 to 00 and leaves the minutes unchanged.
- R10: When the minutes read 59 and the seconds read 51, 53, 55 or 57, the speaker follows the tone one cycle later (1 whenever the tone bit was 1). Otherwise, with test_en low, the speaker is 0.
- R11: While test_en is high, the speaker equals test_tone from the previous cycle, whatever the time.
- R12: While rst is high, and after it, every digit is 0 and the speaker is 0 until counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_min_n | input | 1 | Minute-advance button, active low |
| key_hr_n | input | 1 | Hour-advance button, active low |
| key_sec_n | input | 1 | Seconds-clear button, active low |
| test_en | input | 1 | Routes test_tone to the speaker |
| test_tone | input | 1 | Override signal for the speaker |
| sec_lo | output | 4 | Seconds units, BCD |
| sec_hi | output | 4 | Seconds tens, BCD |
| min_lo | output | 4 | Minutes units, BCD |
| min_hi | output | 4 | Minutes tens, BCD |
| hr_lo | output | 4 | Hours units, BCD |
| hr_hi | output | 4 | Hours tens, BCD |
| speaker | output | 1 | Buzzer drive |

## Verification
The bench builds the clock with TONE_BIT=0, DEB_BIT=1, SCAN_BIT=2 and TICK_BIT=3. A second then lasts 16 cycles, a debounce sample comes every 4 cycles and a scan every 8. A full hour of natural counting fits in 57,600 cycles. That brings the last-minute chime window, the minute and hour carries and the tone pattern within reach, with exact cycle positions. The same small periods let key presses walk the minutes to 59 and the hours to 23 in a few thousand cycles. The bench uses this to check the manual wraps, the priority cases and glitch rejection.

// File: rtl/clock24_pkg.sv
package clock24_pkg;
  typedef logic [3:0] bcd_t;

  localparam int NUM_KEYS = 3;
  localparam int KEY_MIN  = 0;
  localparam int KEY_HR   = 1;
  localparam int KEY_CLR  = 2;

  localparam bcd_t CHIME_MIN_HI = 4'd5;
  localparam bcd_t CHIME_MIN_LO = 4'd9;
  localparam bcd_t CHIME_SEC_HI = 4'd5;
  localparam bcd_t CHIME_SEC_LAST = 4'd7;

  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_ONE  = 2'd1,
    DB_HELD = 2'd2
  } deb_state_t;
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int TONE_BIT = 0,
  parameter int DEB_BIT  = 1,
  parameter int SCAN_BIT = 5,
  parameter int TICK_BIT = 9
) (
  input  logic clk,
  input  logic rst,
  output logic tone,
  output logic deb_stb,
  output logic scan_stb,
  output logic tick_stb
);
  localparam int W = TICK_BIT + 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign tone     = cnt[TONE_BIT];
  assign deb_stb  = &cnt[DEB_BIT:0];
  assign scan_stb = &cnt[SCAN_BIT:0];
  assign tick_stb = &cnt[TICK_BIT:0];

  // R4: the tick is a single-cycle strobe, never two in a row
  a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_stb |=> !tick_stb);
  // R4: every tick coincides with a scan strobe (slower rate nests in faster)
  a_r4_tick_nested: assert property (@(posedge clk) disable iff (rst)
    tick_stb |-> (scan_stb && deb_stb));
endmodule

// File: rtl/key_debounce.sv
module key_debounce
  import clock24_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic raw_n,
  output logic clean_n
);
  logic       meta_q, sync_q;
  deb_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= raw_n;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DB_IDLE;
    end else if (sample) begin
      case (state)
        DB_IDLE: state <= sync_q ? DB_IDLE : DB_ONE;
        DB_ONE:  state <= sync_q ? DB_IDLE : DB_HELD;
        DB_HELD: state <= sync_q ? DB_IDLE : DB_HELD;
        default: state <= DB_IDLE;
      endcase
    end
  end

  assign clean_n = (state != DB_HELD);

  // R5: a press is only recognised on a debounce sample
  a_r5_press_on_sample: assert property (@(posedge clk) disable iff (rst)
    (!clean_n && $past(clean_n)) |-> $past(sample));
  // R5: a high sample releases the key immediately
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (sample && sync_q && !clean_n) |=> clean_n);
endmodule

// File: rtl/key_select.sv
module key_select
  import clock24_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_stb,
  input  logic [NUM_KEYS-1:0] clean_n,
  output logic                adv_min,
  output logic                adv_hr,
  output logic                clr_sec
);
  logic [NUM_KEYS-1:0] nxt_sel, sel_q;

  always_comb begin
    logic taken;
    taken   = 1'b0;
    nxt_sel = '0;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (!taken && !clean_n[k]) begin
        nxt_sel[k] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      adv_min <= 1'b0;
      adv_hr  <= 1'b0;
    end else begin
      adv_min <= scan_stb && nxt_sel[KEY_MIN] && !sel_q[KEY_MIN];
      adv_hr  <= scan_stb && nxt_sel[KEY_HR]  && !sel_q[KEY_HR];
      if (scan_stb) sel_q <= nxt_sel;
    end
  end

  assign clr_sec = sel_q[KEY_CLR];

  // R6: at most one key is selected at a time
  a_r6_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  // R6: each press yields a single-cycle advance
  a_r6_single_min: assert property (@(posedge clk) disable iff (rst)
    adv_min |=> !adv_min);
  a_r6_single_hr: assert property (@(posedge clk) disable iff (rst)
    adv_hr |=> !adv_hr);
  a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
    !(adv_min && adv_hr));
endmodule

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import clock24_pkg::*;
#(
  parameter int WRAP_HI = 5,
  parameter int WRAP_LO = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output bcd_t hi,
  output bcd_t lo,
  output logic at_wrap
);
  localparam bcd_t HI_W = bcd_t'(WRAP_HI);
  localparam bcd_t LO_W = bcd_t'(WRAP_LO);

  assign at_wrap = (hi == HI_W) && (lo == LO_W);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi <= '0;
      lo <= '0;
    end else if (inc) begin
      if (at_wrap) begin
        hi <= '0;
        lo <= '0;
      end else if (lo == 4'd9) begin
        lo <= '0;
        hi <= hi + 1'b1;
      end else begin
        lo <= lo + 1'b1;
      end
    end
  end

  // R1, R2, R3: digits stay legal BCD within the wrap value
  a_r1_digit_range: assert property (@(posedge clk) disable iff (rst)
    (lo <= 4'd9) && ({hi, lo} <= {HI_W, LO_W}));
  // R3: an advance at the wrap value returns to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (at_wrap && inc && !clr) |=> (hi == '0 && lo == '0));
endmodule

// File: rtl/clock_tally.sv
module clock_tally
  import clock24_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic adv_min,
  input  logic adv_hr,
  input  logic clr_sec,
  output bcd_t sec_hi,
  output bcd_t sec_lo,
  output bcd_t min_hi,
  output bcd_t min_lo,
  output bcd_t hr_hi,
  output bcd_t hr_lo
);
  logic s_wrap, m_wrap, h_wrap;
  logic sec_step, sec_carry, min_step, hr_step;

  assign sec_step  = tick && !clr_sec;
  assign sec_carry = sec_step && s_wrap;
  assign min_step  = sec_carry || adv_min;
  assign hr_step   = adv_hr || (sec_carry && m_wrap);

  bcd_wrap_counter #(.WRAP_HI(5), .WRAP_LO(9)) u_sec (
    .clk(clk), .rst(rst), .clr(clr_sec), .inc(sec_step),
    .hi(sec_hi), .lo(sec_lo), .at_wrap(s_wrap));

  bcd_wrap_counter #(.WRAP_HI(5), .WRAP_LO(9)) u_min (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(min_step),
    .hi(min_hi), .lo(min_lo), .at_wrap(m_wrap));

  bcd_wrap_counter #(.WRAP_HI(2), .WRAP_LO(3)) u_hr (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_step),
    .hi(hr_hi), .lo(hr_lo), .at_wrap(h_wrap));

  // R7: seconds read zero after a cycle of clear
  a_r7_clear_holds: assert property (@(posedge clk) disable iff (rst)
    clr_sec |=> (sec_hi == '0 && sec_lo == '0));
  // R8: a manual minute advance alone never moves the hours
  a_r8_manual_min_no_hour: assert property (@(posedge clk) disable iff (rst)
    (adv_min && !adv_hr && !sec_carry) |=> $stable({hr_hi, hr_lo}));
  // R9: a manual hour advance alone never moves the minutes
  a_r9_manual_hr_keeps_min: assert property (@(posedge clk) disable iff (rst)
    (adv_hr && !adv_min && !sec_carry) |=> $stable({min_hi, min_lo}));
  // R3: hours leave 23 only for 00
  a_r3_hour_wrap: assert property (@(posedge clk) disable iff (rst)
    (h_wrap && hr_step) |=> (hr_hi == '0 && hr_lo == '0));
  // R2: a seconds carry at minute 59 advances the hours
  a_r2_hour_carry: assert property (@(posedge clk) disable iff (rst)
    (sec_carry && m_wrap && !h_wrap) |=> !$stable({hr_hi, hr_lo}));
endmodule

// File: rtl/chime_gate.sv
module chime_gate
  import clock24_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  bcd_t min_hi,
  input  bcd_t min_lo,
  input  bcd_t sec_hi,
  input  bcd_t sec_lo,
  input  logic tone,
  input  logic test_en,
  input  logic test_tone,
  output logic spk
);
  logic last_min, beep_sec, window;

  assign last_min = (min_hi == CHIME_MIN_HI) && (min_lo == CHIME_MIN_LO);
  assign beep_sec = (sec_hi == CHIME_SEC_HI) && sec_lo[0] && (sec_lo <= CHIME_SEC_LAST);
  assign window   = last_min && beep_sec;

  always_ff @(posedge clk) begin
    if (rst)          spk <= 1'b0;
    else if (test_en) spk <= test_tone;
    else if (window)  spk <= tone;
    else              spk <= 1'b0;
  end

  // R10: outside minute 59 the speaker stays quiet
  a_r10_quiet_other_min: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !last_min) |=> !spk);
  // R11: test override copies the input with one cycle of delay
  a_r11_override: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (spk == $past(test_tone)));
  // R12: reset silences the speaker
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> !spk);
endmodule

// File: rtl/clock24_chime.sv
module clock24_chime
  import clock24_pkg::*;
#(
  parameter int TONE_BIT = 0,
  parameter int DEB_BIT  = 1,
  parameter int SCAN_BIT = 5,
  parameter int TICK_BIT = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_min_n,
  input  logic       key_hr_n,
  input  logic       key_sec_n,
  input  logic       test_en,
  input  logic       test_tone,
  output logic [3:0] sec_lo,
  output logic [3:0] sec_hi,
  output logic [3:0] min_lo,
  output logic [3:0] min_hi,
  output logic [3:0] hr_lo,
  output logic [3:0] hr_hi,
  output logic       speaker
);
  logic tone, deb_stb, scan_stb, tick_stb;
  logic adv_min, adv_hr, clr_sec;
  logic [NUM_KEYS-1:0] raw_n, clean_n;

  assign raw_n[KEY_MIN] = key_min_n;
  assign raw_n[KEY_HR]  = key_hr_n;
  assign raw_n[KEY_CLR] = key_sec_n;

  rate_divider #(
    .TONE_BIT(TONE_BIT), .DEB_BIT(DEB_BIT),
    .SCAN_BIT(SCAN_BIT), .TICK_BIT(TICK_BIT)
  ) u_div (
    .clk(clk), .rst(rst), .tone(tone),
    .deb_stb(deb_stb), .scan_stb(scan_stb), .tick_stb(tick_stb));

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_debounce u_deb (
      .clk(clk), .rst(rst), .sample(deb_stb),
      .raw_n(raw_n[k]), .clean_n(clean_n[k]));
  end

  key_select u_sel (
    .clk(clk), .rst(rst), .scan_stb(scan_stb), .clean_n(clean_n),
    .adv_min(adv_min), .adv_hr(adv_hr), .clr_sec(clr_sec));

  clock_tally u_tally (
    .clk(clk), .rst(rst), .tick(tick_stb),
    .adv_min(adv_min), .adv_hr(adv_hr), .clr_sec(clr_sec),
    .sec_hi(sec_hi), .sec_lo(sec_lo),
    .min_hi(min_hi), .min_lo(min_lo),
    .hr_hi(hr_hi), .hr_lo(hr_lo));

  chime_gate u_chime (
    .clk(clk), .rst(rst),
    .min_hi(min_hi), .min_lo(min_lo),
    .sec_hi(sec_hi), .sec_lo(sec_lo),
    .tone(tone), .test_en(test_en), .test_tone(test_tone),
    .spk(speaker));
endmodule

// File: tb/clock24_chime_test.sv
module clock24_chime_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, key_min_n, key_hr_n, key_sec_n, test_en, test_tone;
  logic [3:0] sec_lo, sec_hi, min_lo, min_hi, hr_lo, hr_hi;
  logic speaker;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  clock24_chime #(.TONE_BIT(0), .DEB_BIT(1), .SCAN_BIT(2), .TICK_BIT(3)) uut (
    .clk(clk), .rst(rst),
    .key_min_n(key_min_n), .key_hr_n(key_hr_n), .key_sec_n(key_sec_n),
    .test_en(test_en), .test_tone(test_tone),
    .sec_lo(sec_lo), .sec_hi(sec_hi), .min_lo(min_lo), .min_hi(min_hi),
    .hr_lo(hr_lo), .hr_hi(hr_hi), .speaker(speaker));

  always @(posedge clk) if (!rst) edges <= edges + 1;

  localparam int N = 16;
  localparam int SECS [N] = '{1, 9, 10, 59, 60, 61, 3051, 3539, 3540, 3550,
                              3591, 3592, 3593, 3597, 3598, 3600};
  localparam logic [23:0] TIMES [N] = '{24'h000001, 24'h000009, 24'h000010,
    24'h000059, 24'h000100, 24'h000101, 24'h005051, 24'h005859, 24'h005900,
    24'h005910, 24'h005951, 24'h005952, 24'h005953, 24'h005957, 24'h005958,
    24'h010000};
  localparam int HIGHS [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 0, 7, 7, 0, 0};

  function automatic logic [23:0] now_time();
    return {hr_hi, hr_lo, min_hi, min_lo, sec_hi, sec_lo};
  endfunction
  function automatic int mins();  return min_hi * 10 + min_lo; endfunction
  function automatic int hours(); return hr_hi * 10 + hr_lo;   endfunction
  function automatic int secs();  return sec_hi * 10 + sec_lo; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic press(input bit km, input bit kh, input bit kc, input int hold);
    @(negedge clk);
    key_min_n = !km; key_hr_n = !kh; key_sec_n = !kc;
    repeat (hold) @(negedge clk);
    key_min_n = 1'b1; key_hr_n = 1'b1; key_sec_n = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic bump_min(); press(1, 0, 0, 40); press(0, 0, 1, 40); endtask
  task automatic bump_hr();  press(0, 1, 0, 40); press(0, 0, 1, 40); endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int m, h, hi_cnt, guard;
    rst = 1'b1; key_min_n = 1'b1; key_hr_n = 1'b1; key_sec_n = 1'b1;
    test_en = 1'b0; test_tone = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset digits", int'(now_time()), 0);
    chk("R12 reset speaker", int'(speaker), 0);
    rst = 1'b0;

    // R1 R2 R3 R4 R10: natural counting and chime pattern from the table
    for (int i = 0; i < N; i++) begin
      while (edges < 16 * SECS[i]) @(negedge clk);
      chk("R1 R2 R4 time", int'(now_time()), int'(TIMES[i]));
      hi_cnt = 0;
      for (int j = 0; j < 15; j++) begin
        @(negedge clk);
        hi_cnt += int'(speaker);
      end
      chk("R10 tone count", hi_cnt, HIGHS[i]);
    end

    // R7: seconds held at zero while clear is selected
    @(negedge clk); key_sec_n = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 clear holds", secs(), 0);
    repeat (32) @(negedge clk);
    chk("R7 clear still", secs(), 0);
    key_sec_n = 1'b1;
    repeat (40) @(negedge clk);

    // R6: single minute advance, hours untouched
    m = mins(); h = hours();
    bump_min();
    chk("R6 minute step", mins(), (m + 1) % 60);
    chk("R6 hour kept", hours(), h);

    // R6 R5: long hold gives exactly one advance
    m = mins();
    press(1, 0, 0, 200); press(0, 0, 1, 40);
    chk("R6 long hold one step", mins(), (m + 1) % 60);

    // R8: manual minute wrap does not carry
    guard = 0;
    while (mins() != 59 && guard < 70) begin bump_min(); guard++; end
    chk("R8 reached 59", mins(), 59);
    h = hours();
    bump_min();
    chk("R8 minute wrap", mins(), 0);
    chk("R8 hour unchanged", hours(), h);

    // R9 R3: manual hour wrap keeps minutes
    guard = 0;
    while (hours() != 23 && guard < 30) begin bump_hr(); guard++; end
    chk("R9 reached 23", hours(), 23);
    m = mins();
    bump_hr();
    chk("R9 R3 hour wrap", hours(), 0);
    chk("R9 minute unchanged", mins(), m);

    // R6: minute beats hour
    m = mins(); h = hours();
    press(1, 1, 0, 40); press(0, 0, 1, 40);
    chk("R6 priority minute", mins(), (m + 1) % 60);
    chk("R6 priority hour kept", hours(), h);

    // R6: hour beats clear, seconds keep counting
    repeat (48) @(negedge clk);
    h = hours();
    press(0, 1, 1, 40);
    chk("R6 hour over clear", hours(), (h + 1) % 24);
    chk("R6 seconds not cleared", int'(secs() != 0), 1);

    // R5: short glitch ignored
    press(0, 0, 1, 40);
    m = mins();
    @(negedge clk); key_min_n = 1'b0;
    repeat (3) @(negedge clk);
    key_min_n = 1'b1;
    repeat (60) @(negedge clk);
    chk("R5 glitch ignored", mins(), m);

    // R11: test override
    test_en = 1'b1; test_tone = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 override high", int'(speaker), 1);
    test_tone = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 override low", int'(speaker), 0);
    test_en = 1'b0;

    // R12: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 rerun digits", int'(now_time()), 0);
    chk("R12 rerun speaker", int'(speaker), 0);
    rst = 1'b0;

    summary();
    $finish;
  end
endmodule